// File: doc/BRIEF.md
# Position Latch Capture Unit

This block copies a running position count into a latch register when an armed trigger event arrives. There are two trigger sources. The first is a rising edge on the index (zero-mark) input. The second is an external latch input, which can be armed for its rising edge, its falling edge, or both. Software arms each source through its own enable bit. The block raises a per-source valid flag when that source captures. A source captures only once per arming, so later pulses leave the held value alone.

Both trigger inputs must already be synchronised to `clk`. The block finds edges by comparing each input against its value in the previous cycle. It samples `count_i` in the cycle where an edge is first seen. The captured value appears on `latch_o` after the next rising clock edge.

There is no streaming data path. Every pin is a plain level signal with no valid/ready handshake, so the block applies no back-pressure and needs none.

Top module: `pos_latch_capture`

## Requirements
- R1: With `arm_idx_i` high and `idx_valid_o` low, a cycle where `idx_i` is 1 and was 0 in the previous cycle loads `count_i` of that cycle into `latch_o`; the new value is visible from the next clock edge.
- R2: While `arm_idx_i` is high, rising or falling edges on `ext_i` change neither `latch_o` nor `ext_valid_o`.
- R3: With `arm_ext_rise_i` high, `arm_idx_i` low and `ext_valid_o` low, a 0-to-1 change of `ext_i` loads `count_i` of that cycle into `latch_o`.
- R4: With `arm_ext_fall_i` high, `arm_idx_i` low and `ext_valid_o` low, a 1-to-0 change of `ext_i` loads `count_i` of that cycle into `latch_o`.
- R5: While a source's valid flag is set, further edges on that source do not change `latch_o`.
- R6: `idx_valid_o` and `ext_valid_o` are independent flags. Each goes high on the same clock edge that its source writes `latch_o`.
- R7: A valid flag is cleared on the clock edge after its enables are all low. For the external source, that means both `arm_ext_rise_i` and `arm_ext_fall_i` are low. Only after the flag clears can the re-armed source capture again.
- R8: `latch_lo_o` always equals bits 15:0 of `latch_o`.
- R9: During and after reset, `latch_o` is 0 and both valid flags are 0. The edge history resets to low, so an input that is high in the first cycle after reset counts as a rising edge.
- R10: An edge on a source whose enable bits are all low changes neither `latch_o` nor that source's flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| count_i | input | CNT_W (32) | Position count to be captured |
| idx_i | input | 1 | Synchronised index input |
| ext_i | input | 1 | Synchronised external latch input |
| arm_idx_i | input | 1 | Arm the index source; also blocks the external source |
| arm_ext_rise_i | input | 1 | Arm the external source on its rising edge |
| arm_ext_fall_i | input | 1 | Arm the external source on its falling edge |
| latch_o | output | CNT_W (32) | Captured count |
| latch_lo_o | output | VIEW_W (16) | Low half of the captured count |
| idx_valid_o | output | 1 | Index capture has occurred since arming |
| ext_valid_o | output | 1 | External capture has occurred since arming |

## Verification
The assertions assume that `idx_i` and `ext_i` are already synchronous to `clk` and stay stable between clock edges. Under that assumption, one sampled change is exactly one edge. The stimulus changes every input on the falling clock edge. It toggles the two trigger inputs at random, holds each enable pattern for a random number of cycles, and drops enables in the middle of runs so that flags clear and sources re-arm. Directed sequences cover the index source blocking the external one, both external edges being armed together, and an input that is high as reset releases.

// File: rtl/plc_pkg.sv
package plc_pkg;
  localparam int unsigned NUM_SRC = 2;
  localparam int unsigned SRC_IDX = 0;
  localparam int unsigned SRC_EXT = 1;
endpackage

// File: rtl/plc_edge_det.sv
module plc_edge_det #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] sig_i,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] hist_q;

  for (genvar g = 0; g < N; g++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n) hist_q[g] <= 1'b0;
      else        hist_q[g] <= sig_i[g];
    end
    assign rise_o[g] =  sig_i[g] & ~hist_q[g];
    assign fall_o[g] = ~sig_i[g] &  hist_q[g];
  end
endmodule

// File: rtl/plc_arm.sv
module plc_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic enable_i,
  input  logic block_i,
  input  logic event_i,
  output logic capture_o,
  output logic valid_o
);
  assign capture_o = enable_i & ~block_i & ~valid_o & event_i;

  always_ff @(posedge clk) begin
    if (!rst_n)         valid_o <= 1'b0;
    else if (!enable_i) valid_o <= 1'b0;
    else if (capture_o) valid_o <= 1'b1;
  end
endmodule

// File: rtl/plc_latch_reg.sv
module plc_latch_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)      q_o <= '0;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/pos_latch_capture.sv
module pos_latch_capture #(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned VIEW_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              idx_i,
  input  logic              ext_i,
  input  logic              arm_idx_i,
  input  logic              arm_ext_rise_i,
  input  logic              arm_ext_fall_i,
  output logic [CNT_W-1:0]  latch_o,
  output logic [VIEW_W-1:0] latch_lo_o,
  output logic              idx_valid_o,
  output logic              ext_valid_o
);
  import plc_pkg::*;

  localparam int unsigned LO_W = (VIEW_W < CNT_W) ? VIEW_W : CNT_W;

  logic [NUM_SRC-1:0] trig, rise, fall;
  logic cap_idx, cap_ext, ext_event, ext_enable;

  assign trig[SRC_IDX] = idx_i;
  assign trig[SRC_EXT] = ext_i;

  plc_edge_det #(.N(NUM_SRC)) u_edge (
    .clk(clk), .rst_n(rst_n), .sig_i(trig), .rise_o(rise), .fall_o(fall)
  );

  // Index source: never blocked.
  plc_arm u_arm_idx (
    .clk(clk), .rst_n(rst_n), .enable_i(arm_idx_i), .block_i(1'b0),
    .event_i(rise[SRC_IDX]), .capture_o(cap_idx), .valid_o(idx_valid_o)
  );

  // External source: either edge may be armed; index arming takes priority.
  assign ext_enable = arm_ext_rise_i | arm_ext_fall_i;
  assign ext_event  = (arm_ext_rise_i & rise[SRC_EXT]) |
                      (arm_ext_fall_i & fall[SRC_EXT]);

  plc_arm u_arm_ext (
    .clk(clk), .rst_n(rst_n), .enable_i(ext_enable), .block_i(arm_idx_i),
    .event_i(ext_event), .capture_o(cap_ext), .valid_o(ext_valid_o)
  );

  plc_latch_reg #(.W(CNT_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .load_i(cap_idx | cap_ext),
    .d_i(count_i), .q_o(latch_o)
  );

  always_comb begin
    latch_lo_o = '0;
    latch_lo_o[LO_W-1:0] = latch_o[LO_W-1:0];
  end
endmodule

// File: rtl/plc_capture_chk.sv
module plc_capture_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] count_i,
  input logic             idx_i,
  input logic             arm_idx_i,
  input logic             arm_ext_rise_i,
  input logic             arm_ext_fall_i,
  input logic [CNT_W-1:0] latch_o,
  input logic             idx_valid_o,
  input logic             ext_valid_o,
  input logic             cap_idx,
  input logic             cap_ext
);
  // R1
  idx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_idx |=> latch_o == $past(count_i));

  // R2
  idx_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm_idx_i |-> !cap_ext);

  // R5
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cap_idx || cap_ext) |=> $stable(latch_o));

  // R6
  idx_valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idx_valid_o) |-> $past(idx_i) && $past(arm_idx_i));

  // R7
  idx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !arm_idx_i |=> !idx_valid_o);

  // R7
  ext_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(arm_ext_rise_i || arm_ext_fall_i) |=> !ext_valid_o);
endmodule

bind pos_latch_capture plc_capture_chk #(.CNT_W(CNT_W)) u_capture_chk (
  .clk(clk), .rst_n(rst_n), .count_i(count_i), .idx_i(idx_i),
  .arm_idx_i(arm_idx_i), .arm_ext_rise_i(arm_ext_rise_i),
  .arm_ext_fall_i(arm_ext_fall_i), .latch_o(latch_o),
  .idx_valid_o(idx_valid_o), .ext_valid_o(ext_valid_o),
  .cap_idx(cap_idx), .cap_ext(cap_ext)
);

// File: tb/tb_pos_latch_capture.sv
module tb_pos_latch_capture;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] count_i;
  logic        idx_i, ext_i, arm_idx_i, arm_ext_rise_i, arm_ext_fall_i;
  logic [31:0] latch_o;
  logic [15:0] latch_lo_o;
  logic        idx_valid_o, ext_valid_o;

  int checks = 0;
  int fails  = 0;

  // model state
  logic [31:0] m_latch;
  logic m_vi, m_ve, m_pidx, m_pext;

  always #4 clk = ~clk;

  pos_latch_capture dut (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic cap_idx_f(logic a, logic v, logic s, logic p);
    return a & ~v & s & ~p;
  endfunction

  function automatic logic cap_ext_f(logic ar, logic af, logic ai, logic v,
                                     logic s, logic p);
    return ~ai & ~v & ((ar & s & ~p) | (af & ~s & p));
  endfunction

  // Inputs are already applied (at negedge); advance model and DUT one cycle.
  task automatic step(string tag);
    logic ci, ce;
    ci = cap_idx_f(arm_idx_i, m_vi, idx_i, m_pidx);
    ce = cap_ext_f(arm_ext_rise_i, arm_ext_fall_i, arm_idx_i, m_ve, ext_i, m_pext);
    if (ci || ce) m_latch = count_i;
    m_vi   = !arm_idx_i ? 1'b0 : (ci ? 1'b1 : m_vi);
    m_ve   = !(arm_ext_rise_i | arm_ext_fall_i) ? 1'b0 : (ce ? 1'b1 : m_ve);
    m_pidx = idx_i;
    m_pext = ext_i;
    @(posedge clk);
    @(negedge clk);
    chk(tag, latch_o, m_latch);
    chk("R8 low view", {16'h0, latch_lo_o}, {16'h0, m_latch[15:0]});
    chk("R6 idx flag", {31'h0, idx_valid_o}, {31'h0, m_vi});
    chk("R6 ext flag", {31'h0, ext_valid_o}, {31'h0, m_ve});
  endtask

  task automatic drive(logic ai, logic ar, logic af, logic ix, logic ex,
                       logic [31:0] cnt);
    arm_idx_i = ai; arm_ext_rise_i = ar; arm_ext_fall_i = af;
    idx_i = ix; ext_i = ex; count_i = cnt;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    int seed;
    int hold;
    logic [2:0] arms;
    seed = 32'h5EED_0042;
    void'($urandom(seed));
    rst_n = 1'b0;
    drive(0, 0, 0, 0, 0, 32'h0);
    m_latch = '0; m_vi = 0; m_ve = 0; m_pidx = 0; m_pext = 0;
    repeat (3) @(negedge clk);
    // R9: reset values
    chk("R9 reset latch", latch_o, 32'h0);
    chk("R9 reset flags", {30'h0, idx_valid_o, ext_valid_o}, 32'h0);
    // R9: index high as reset releases counts as rising edge
    drive(1, 0, 0, 1, 0, 32'hA5A5_1234);
    rst_n = 1'b1;
    step("R9 first-cycle edge");
    // R5: further index pulses ignored while valid
    drive(1, 0, 0, 0, 0, 32'h1111_1111); step("R5 hold");
    drive(1, 0, 0, 1, 0, 32'h2222_2222); step("R5 second pulse ignored");
    // R2: external edges ignored while index armed
    drive(1, 1, 1, 1, 1, 32'h3333_3333); step("R2 ext rise blocked");
    drive(1, 1, 1, 1, 0, 32'h4444_4444); step("R2 ext fall blocked");
    // R7: drop index arm, flag clears, re-arm and capture again
    drive(0, 0, 0, 0, 0, 32'h5555_5555); step("R7 flag clears");
    drive(1, 0, 0, 0, 0, 32'h6666_6666); step("R7 rearmed idle");
    drive(1, 0, 0, 1, 0, 32'h7777_ABCD); step("R1 index capture");
    drive(0, 0, 0, 0, 0, 32'h0);         step("R7 drop");
    // R10: unarmed edges
    drive(0, 0, 0, 1, 1, 32'h8888_8888); step("R10 unarmed edges");
    drive(0, 0, 0, 0, 0, 32'h9999_9999); step("R10 unarmed falls");
    // R3: external rising
    drive(0, 1, 0, 0, 1, 32'hCAFE_0001); step("R3 ext rise");
    drive(0, 1, 0, 0, 0, 32'hCAFE_0002); step("R5 ext held");
    drive(0, 0, 0, 0, 0, 32'h0);         step("R7 ext drop");
    // R4: external falling
    drive(0, 0, 1, 0, 1, 32'hBEEF_0001); step("R4 no capture on rise");
    drive(0, 0, 1, 0, 0, 32'hBEEF_0002); step("R4 ext fall");
    drive(0, 0, 0, 0, 0, 32'h0);         step("R7 ext drop");

    // constrained random
    arms = 3'b000; hold = 0;
    for (int i = 0; i < 4000; i++) begin
      logic ix, ex;
      string tag;
      if (hold == 0) begin
        arms = 3'($urandom_range(0, 7));
        if (arms[2] && ($urandom_range(0, 3) != 0)) arms[2] = 1'b0;
        hold = $urandom_range(1, 20);
      end
      hold--;
      ix = ($urandom_range(0, 3) == 0) ? ~idx_i : idx_i;
      ex = ($urandom_range(0, 3) == 0) ? ~ext_i : ext_i;
      drive(arms[2], arms[1], arms[0], ix, ex, $urandom);
      if (cap_idx_f(arms[2], m_vi, ix, m_pidx))                          tag = "R1 random";
      else if (cap_ext_f(arms[1], 1'b0, arms[2], m_ve, ex, m_pext))      tag = "R3 random";
      else if (cap_ext_f(1'b0, arms[0], arms[2], m_ve, ex, m_pext))      tag = "R4 random";
      else if (arms[2] && (ex != m_pext))                                tag = "R2 random";
      else if (m_vi || m_ve)                                             tag = "R5 random";
      else                                                               tag = "R10 random";
      step(tag);
    end

    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule